// File: doc/BRIEF.md
# LCD Panel Power-Up Sequencer

This block brings a display driver chip out of power-off. It turns on the core supply first and waits for its power-good flag. After a programmed delay it turns on the I/O supply and waits for that supply's power-good flag. It holds the panel reset line low for a minimum time, releases it and lets the panel settle. It then sends two commands. The first is a wake opcode. After a fixed wait, the second is a pixel-format opcode followed by one parameter byte.

Bytes leave the block on a valid/ready byte interface that feeds an SPI or DSI command sender. All waits are counted in clock cycles derived from a clock-frequency parameter, so the same millisecond figures hold at any system clock. A missing or lost supply drives the block to a safe error state. A completed sequence holds a ready flag until software issues the next start request.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, and while no start request arrives, both supply enables, the panel reset line (active low, so it reads 0), cmd_valid_o, done_o and error_o are all 0, whatever the power-good and ready inputs do.
- R2: A start request raises core_en_o on the next clock. If core_pg_i has not been seen within PG_TMO_MS (default 50 ms), the block enters the error state. The same rule applies to io_pg_i after io_en_o rises.
- R3: io_en_o rises IO_DLY_MS after core_pg_i is first seen (IO_DLY_MS must lie between 1 and 10). io_en_o is never high while core_en_o is low.
- R4: panel_rst_no stays low for RST_LO_MS (at least 10 ms) after io_pg_i is seen, and then goes high. It is never high while io_en_o is low.
- R5: RST_HI_MS (120 ms) after the reset release, the first byte offered is the wake opcode 0x11.
- R6: SLP_MS (120 ms) after the wake byte is accepted, the pixel-format opcode 0x3A is offered. Its parameter byte is offered in the cycle right after the opcode is accepted, with no gap.
- R7: The parameter byte comes from fmt_sel_i as sampled with the start request: 2'b00 gives 0x55 (16-bit), 2'b01 gives 0x66 (18-bit), and 2'b10 or 2'b11 gives 0x77 (24-bit). Later changes to fmt_sel_i have no effect.
- R8: Once cmd_valid_o is high, it and cmd_byte_o stay unchanged until cmd_ready_i accepts the byte.
- R9: If a power-good flag drops at any time after it has been seen, up to and including the done state, the block enters the error state on the next clock. In the error state all enables are low, reset is low, no byte is offered and error_o is 1. The error state holds until a start request, which clears error_o and restarts the sequence.
- R10: done_o rises in the cycle after the parameter byte is accepted. It stays high until the next start request. Start requests that arrive mid-sequence are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sequence start request |
| core_pg_i | input | 1 | Core supply power-good |
| io_pg_i | input | 1 | I/O supply power-good |
| fmt_sel_i | input | 2 | Pixel format select, sampled at start |
| cmd_ready_i | input | 1 | Command sender accepts the current byte |
| core_en_o | output | 1 | Core supply enable |
| io_en_o | output | 1 | I/O supply enable |
| panel_rst_no | output | 1 | Panel reset, active low |
| cmd_valid_o | output | 1 | Command byte valid |
| cmd_byte_o | output | 8 | Command or parameter byte |
| done_o | output | 1 | Panel initialised and ready |
| error_o | output | 1 | Supply fault or timeout |

## Verification
The bench times each step edge to edge in cycles:
- the I/O enable delay,
- the reset-low hold,
- the settle time before the wake byte,
- the wait before the format opcode.

An off-by-a-millisecond timer or a swapped delay would land outside the window. It stalls the ready input to catch a byte that changes or drops before acceptance. It checks that the parameter follows the opcode in the very next cycle, and it changes fmt_sel_i after the start to catch a design that reads the format late. It also lets the core supply time out and drops a power-good flag mid-sequence and in the done state, where a faulty design would leave a supply on or reset released. Finally, it sends a start pulse mid-sequence, which a faulty design would use to restart the timing.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CORE,
    ST_IO_DLY,
    ST_IO,
    ST_RST_LO,
    ST_RST_HI,
    ST_SLP,
    ST_SLP_WAIT,
    ST_FMT,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  typedef enum logic [1:0] {
    CP_IDLE,
    CP_OP,
    CP_PAR
  } cmd_phase_e;

  localparam logic [7:0] OP_WAKE    = 8'h11;
  localparam logic [7:0] OP_PIX_FMT = 8'h3A;

  function automatic logic [7:0] fmt_code(logic [1:0] sel);
    case (sel)
      2'd0:    return 8'h55;
      2'd1:    return 8'h66;
      default: return 8'h77;
    endcase
  endfunction

endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_seq_pwr_mon.sv
module lcd_seq_pwr_mon
  import lcd_seq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       core_pg_i,
  input  logic       io_pg_i,
  output logic       fault_o
);

  logic core_armed, io_armed;

  // a flag is watched only once it has been seen
  always_comb begin
    core_armed = 1'b0;
    io_armed   = 1'b0;
    case (state_i)
      ST_IO_DLY, ST_IO: core_armed = 1'b1;
      ST_RST_LO, ST_RST_HI, ST_SLP, ST_SLP_WAIT, ST_FMT, ST_DONE: begin
        core_armed = 1'b1;
        io_armed   = 1'b1;
      end
      default: ;
    endcase
  end

  assign fault_o = (core_armed && !core_pg_i) || (io_armed && !io_pg_i);

endmodule

// File: rtl/lcd_seq_cmd.sv
module lcd_seq_cmd
  import lcd_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       abort_i,
  input  logic       go_i,
  input  logic       with_par_i,
  input  logic [7:0] op_i,
  input  logic [7:0] par_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] byte_o,
  output logic       done_o
);

  cmd_phase_e phase_q;
  logic [7:0] byte_q, par_q;
  logic       need_par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= CP_IDLE;
      byte_q     <= '0;
      par_q      <= '0;
      need_par_q <= 1'b0;
    end else if (abort_i) begin
      phase_q <= CP_IDLE;
    end else begin
      case (phase_q)
        CP_IDLE: if (go_i) begin
          byte_q     <= op_i;
          par_q      <= par_i;
          need_par_q <= with_par_i;
          phase_q    <= CP_OP;
        end
        CP_OP: if (ready_i) begin
          if (need_par_q) begin
            byte_q  <= par_q;
            phase_q <= CP_PAR;
          end else begin
            phase_q <= CP_IDLE;
          end
        end
        CP_PAR: if (ready_i) phase_q <= CP_IDLE;
        default: phase_q <= CP_IDLE;
      endcase
    end
  end

  assign valid_o = (phase_q != CP_IDLE);
  assign byte_o  = byte_q;
  assign done_o  = ready_i && ((phase_q == CP_OP && !need_par_q) || phase_q == CP_PAR);

  // R8: byte held until accepted
  p_byte_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !abort_i |=> valid_o && $stable(byte_o));

  // R6: parameter directly after the format opcode
  p_par_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !abort_i && byte_o == OP_PIX_FMT && !done_o |=> valid_o);

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned PG_TMO_MS = 50,
  parameter int unsigned IO_DLY_MS = 2,
  parameter int unsigned RST_LO_MS = 10,
  parameter int unsigned RST_HI_MS = 120,
  parameter int unsigned SLP_MS    = 120
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       core_pg_i,
  input  logic       io_pg_i,
  input  logic [1:0] fmt_sel_i,
  input  logic       cmd_ready_i,
  output logic       core_en_o,
  output logic       io_en_o,
  output logic       panel_rst_no,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_byte_o,
  output logic       done_o,
  output logic       error_o
);

  localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
  localparam int unsigned MAX_A  = (PG_TMO_MS > IO_DLY_MS) ? PG_TMO_MS : IO_DLY_MS;
  localparam int unsigned MAX_B  = (RST_LO_MS > RST_HI_MS) ? RST_LO_MS : RST_HI_MS;
  localparam int unsigned MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_MS = (MAX_C > SLP_MS) ? MAX_C : SLP_MS;
  localparam int unsigned CNT_W  = $clog2(MAX_MS * CYC_PER_MS + 1);

  localparam logic [CNT_W-1:0] T_PG     = CNT_W'(PG_TMO_MS * CYC_PER_MS);
  localparam logic [CNT_W-1:0] T_IO     = CNT_W'(IO_DLY_MS * CYC_PER_MS);
  localparam logic [CNT_W-1:0] T_RST_LO = CNT_W'(RST_LO_MS * CYC_PER_MS);
  localparam logic [CNT_W-1:0] T_RST_HI = CNT_W'(RST_HI_MS * CYC_PER_MS);
  localparam logic [CNT_W-1:0] T_SLP    = CNT_W'(SLP_MS * CYC_PER_MS);

  seq_state_e       state_q, state_d;
  logic             tmr_load, tmr_exp, fault_w;
  logic [CNT_W-1:0] tmr_val;
  logic [1:0]       fmt_q;
  logic             enter_slp, enter_fmt, cmd_done, start_ok;

  assign start_ok = start_i && (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_ERR);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_ERR, ST_DONE: if (start_i) state_d = ST_CORE;
      ST_CORE:     if (core_pg_i) state_d = ST_IO_DLY; else if (tmr_exp) state_d = ST_ERR;
      ST_IO_DLY:   if (tmr_exp) state_d = ST_IO;
      ST_IO:       if (io_pg_i) state_d = ST_RST_LO; else if (tmr_exp) state_d = ST_ERR;
      ST_RST_LO:   if (tmr_exp) state_d = ST_RST_HI;
      ST_RST_HI:   if (tmr_exp) state_d = ST_SLP;
      ST_SLP:      if (cmd_done) state_d = ST_SLP_WAIT;
      ST_SLP_WAIT: if (tmr_exp) state_d = ST_FMT;
      ST_FMT:      if (cmd_done) state_d = ST_DONE;
      default:     state_d = ST_IDLE;
    endcase
    if (fault_w && !start_ok) state_d = ST_ERR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fmt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok) fmt_q <= fmt_sel_i;
    end
  end

  always_comb begin
    case (state_d)
      ST_CORE, ST_IO: tmr_val = T_PG;
      ST_IO_DLY:      tmr_val = T_IO;
      ST_RST_LO:      tmr_val = T_RST_LO;
      ST_RST_HI:      tmr_val = T_RST_HI;
      ST_SLP_WAIT:    tmr_val = T_SLP;
      default:        tmr_val = '0;
    endcase
  end
  assign tmr_load = (state_d != state_q);

  lcd_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  lcd_seq_pwr_mon u_pwr_mon (
    .state_i   (state_q),
    .core_pg_i (core_pg_i),
    .io_pg_i   (io_pg_i),
    .fault_o   (fault_w)
  );

  assign enter_slp = (state_d == ST_SLP) && (state_q != ST_SLP);
  assign enter_fmt = (state_d == ST_FMT) && (state_q != ST_FMT);

  lcd_seq_cmd u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (state_d == ST_ERR),
    .go_i       (enter_slp || enter_fmt),
    .with_par_i (enter_fmt),
    .op_i       (enter_fmt ? OP_PIX_FMT : OP_WAKE),
    .par_i      (fmt_code(fmt_q)),
    .ready_i    (cmd_ready_i),
    .valid_o    (cmd_valid_o),
    .byte_o     (cmd_byte_o),
    .done_o     (cmd_done)
  );

  always_comb begin
    core_en_o    = 1'b0;
    io_en_o      = 1'b0;
    panel_rst_no = 1'b0;
    case (state_q)
      ST_CORE, ST_IO_DLY: core_en_o = 1'b1;
      ST_IO, ST_RST_LO: begin
        core_en_o = 1'b1;
        io_en_o   = 1'b1;
      end
      ST_RST_HI, ST_SLP, ST_SLP_WAIT, ST_FMT, ST_DONE: begin
        core_en_o    = 1'b1;
        io_en_o      = 1'b1;
        panel_rst_no = 1'b1;
      end
      default: ;
    endcase
  end

  assign done_o  = (state_q == ST_DONE);
  assign error_o = (state_q == ST_ERR);

  p_io_needs_core_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |-> core_en_o);

  p_rst_needs_io_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_rst_no |-> io_en_o);

  p_cmd_after_rst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> panel_rst_no);

  p_err_safe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !core_en_o && !io_en_o && !panel_rst_no && !cmd_valid_o && !done_o);

  p_io_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_rst_no && !io_pg_i && !start_i |=> error_o);

  p_done_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i && core_pg_i && io_pg_i |=> done_o);

endmodule

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb;

  // CLK_HZ scaled down: 10 cycles per ms
  localparam int CPM = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, core_pg = 1'b0, io_pg = 1'b0, ready = 1'b0;
  logic [1:0] fmt_sel = 2'd0;
  logic       core_en, io_en, panel_rst_n, cmd_valid, done, error;
  logic [7:0] cmd_byte;

  always #10 clk = ~clk;

  lcd_pwr_seq #(.CLK_HZ(CPM * 1000)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .core_pg_i(core_pg),
    .io_pg_i(io_pg), .fmt_sel_i(fmt_sel), .cmd_ready_i(ready),
    .core_en_o(core_en), .io_en_o(io_en), .panel_rst_no(panel_rst_n),
    .cmd_valid_o(cmd_valid), .cmd_byte_o(cmd_byte), .done_o(done), .error_o(error)
  );

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // vector table: fmt_sel, ready stall cycles, expected parameter, mid-run start poke
  localparam int NV = 4;
  localparam int V_FMT   [NV] = '{0, 1, 2, 3};
  localparam int V_STALL [NV] = '{0, 3, 1, 5};
  localparam int V_PAR   [NV] = '{8'h55, 8'h66, 8'h77, 8'h77};
  localparam int V_POKE  [NV] = '{0, 1, 0, 1};

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic sig(int k);
    case (k)
      0: return core_en;
      1: return io_en;
      2: return panel_rst_n;
      3: return cmd_valid;
      4: return done;
      default: return error;
    endcase
  endfunction

  task automatic wait_hi(int k, int lim, output int ts);
    ts = -1;
    for (int i = 0; i < lim; i++) begin
      if (sig(k)) begin
        ts = cyc;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic accept(int stall, int exp, string req);
    bit ok = 1'b1;
    for (int i = 0; i < stall; i++) begin
      if (!cmd_valid || cmd_byte != exp[7:0]) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok && cmd_valid && cmd_byte == exp[7:0], req, "byte held until ready", cmd_byte, exp);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic run_seq(int v);
    int t, ts;
    @(negedge clk);
    fmt_sel = 2'(V_FMT[v]); start = 1'b1; core_pg = 1'b0; io_pg = 1'b0;
    @(negedge clk);
    start = 1'b0;
    fmt_sel = ~2'(V_FMT[v]);
    chk(core_en && !done && !error, "R2", "core enable after start", core_en, 1);
    repeat (48) @(negedge clk);
    core_pg = 1'b1; t = cyc;
    wait_hi(1, 300, ts);
    chk(ts >= 0 && ts - t >= 2 * CPM && ts - t <= 2 * CPM + 4, "R3", "io enable delay", ts - t, 2 * CPM + 2);
    repeat (3) @(negedge clk);
    chk(!panel_rst_n, "R4", "reset low before io good", panel_rst_n, 0);
    io_pg = 1'b1; t = cyc;
    wait_hi(2, 500, ts);
    chk(ts >= 0 && ts - t >= 10 * CPM && ts - t <= 10 * CPM + 4, "R4", "reset low hold", ts - t, 10 * CPM + 2);
    t = ts;
    if (V_POKE[v] != 0) begin
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_hi(3, 3000, ts);
    chk(ts >= 0 && ts - t >= 120 * CPM && ts - t <= 120 * CPM + 4, "R5", "settle before wake", ts - t, 120 * CPM + 1);
    chk(cmd_byte == 8'h11, "R5", "wake opcode", cmd_byte, 8'h11);
    accept(V_STALL[v], 8'h11, "R8");
    t = cyc;
    wait_hi(3, 3000, ts);
    chk(ts >= 0 && ts - t >= 120 * CPM && ts - t <= 120 * CPM + 4, "R6", "wait after wake", ts - t, 120 * CPM + 1);
    chk(cmd_byte == 8'h3A, "R6", "format opcode", cmd_byte, 8'h3A);
    accept(V_STALL[v], 8'h3A, "R8");
    chk(cmd_valid && cmd_byte == V_PAR[v][7:0], "R7", "parameter right after opcode", cmd_byte, V_PAR[v]);
    accept(V_STALL[v], V_PAR[v], "R8");
    chk(done && !cmd_valid, "R10", "done after parameter", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual %0d expected below %0d", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ts, t;
    repeat (3) @(negedge clk);
    chk(!core_en && !io_en && !panel_rst_n && !cmd_valid && !done && !error, "R1", "reset state", core_en, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      core_pg = i[0]; io_pg = i[1]; ready = i[2];
      @(negedge clk);
    end
    core_pg = 1'b0; io_pg = 1'b0; ready = 1'b0;
    chk(!core_en && !io_en && !panel_rst_n && !cmd_valid && !done && !error, "R1", "idle without start", io_en, 0);

    for (int v = 0; v < NV; v++) run_seq(v);

    repeat (40) @(negedge clk);
    chk(done, "R10", "done held", done, 1);

    core_pg = 1'b0;
    @(negedge clk);
    chk(error && !core_en && !io_en && !panel_rst_n && !done, "R9", "core drop in done", error, 1);
    repeat (30) @(negedge clk);
    chk(error && !core_en, "R9", "error held", error, 1);

    start = 1'b1; io_pg = 1'b0; t = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(!error && core_en, "R9", "start clears error", error, 0);
    wait_hi(5, 1000, ts);
    chk(ts >= 0 && ts - t >= 50 * CPM && ts - t <= 50 * CPM + 4, "R2", "core good timeout", ts - t, 50 * CPM + 2);
    chk(!core_en && !io_en && !panel_rst_n, "R2", "safe after timeout", core_en, 0);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    core_pg = 1'b1;
    wait_hi(1, 300, ts);
    repeat (4) @(negedge clk);
    io_pg = 1'b1;
    wait_hi(2, 500, ts);
    repeat (10) @(negedge clk);
    io_pg = 1'b0;
    @(negedge clk);
    chk(error && !panel_rst_n && !io_en && !core_en && !cmd_valid, "R9", "io drop mid-sequence", error, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule